// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a regular tick for system software. A 20-bit counter climbs from zero by one each clock until it equals a programmed limit, then returns to zero on the following clock. Each such return raises a sticky flag and adds one to a 12-bit tally of completed periods. The flag, gated by an interrupt enable, drives a level interrupt line.

Software reaches the timer through four 32-bit registers on a simple register bus that reads combinationally and writes on the clock edge. A configuration register holds the limit and two enables. A read-only status word shows the flag. Two read-only views each return the tally together with the live count. Reading one of them acknowledges the event, which drops the flag and empties the tally. Reading the other one has no side effect, so a debugger can inspect the timer without disturbing it. Only address bits 3:2 select a register.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the configuration register (offset 0x0) reads 0x000FFFFF. The status (0x4), acknowledging view (0x8) and non-acknowledging view (0xC) read zero, and the interrupt output is low.
- R2: A write to offset 0x0 stores the limit in bits 19:0, the count enable in bit 24 and the interrupt enable in bit 25. A read returns these fields, and every other bit reads zero.
- R3: While the timer runs and the count is not equal to the limit, the count rises by exactly one per clock.
- R4: When the timer runs and the count equals the limit, the next clock sets the count to zero, sets the flag and adds one to the tally.
- R5: The tally saturates at 4095 and does not wrap.
- R6: Both views at 0x8 and 0xC read as {tally[11:0], count[19:0]}. A read at 0x8 clears the flag and the tally at the end of that cycle.
- R7: A read at 0xC changes neither the flag nor the tally.
- R8: If an acknowledging read falls in the same cycle as a wrap, the new event wins. The flag stays set and the tally becomes 1.
- R9: When the count enable is cleared, the counter keeps advancing until it wraps to zero. It then holds at zero until the enable is set again.
- R10: The interrupt output is high exactly when the flag and the interrupt enable are both set.
- R11: The status register shows the flag in bit 0, and all its other bits read zero.
- R12: Writes to offsets 0x4, 0x8 and 0xC have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register; bits 3:2 decode |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe; read side effects apply at the clock edge |
| bus_rdata | output | 32 | Combinational read data for the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
Two cases are hard to reach from the ports. One is the tally at saturation, which needs 4095 wraps with no acknowledging read in between. The bench sets the limit to zero so that every clock wraps, then idles for more than 4095 cycles. The other is an acknowledging read that falls exactly on the wrap cycle. The bench predicts the count with its own model and issues the read in the cycle where the model count equals the limit. Random traffic with small limits then mixes reads, writes and enable changes, so that wraps, acknowledgments and stop-at-zero events overlap in many orders.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_CNT_W   = 20;
    localparam int PIT_TALLY_W = 12;
    localparam int PIT_DATA_W  = 32;
    localparam int PIT_ADDR_W  = 4;

    // bit positions inside the configuration word
    localparam int PIT_EN_BIT  = 24;
    localparam int PIT_IEN_BIT = 25;

    typedef enum logic [1:0] {
        SEL_CONFIG = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_PEEK   = 2'd3
    } pit_sel_e;

    typedef struct packed {
        logic                 irq_en;
        logic                 cnt_en;
        logic [PIT_CNT_W-1:0] limit;
    } pit_cfg_t;

    // registers are word aligned: drop the two byte-select bits
    function automatic pit_sel_e pit_decode(input logic [PIT_ADDR_W-1:0] a);
        return pit_sel_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/pit_core.sv
module pit_core #(
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    input  logic [CNT_W-1:0]   limit,
    input  logic               ack,
    output logic [CNT_W-1:0]   count,
    output logic               flag,
    output logic [TALLY_W-1:0] tally
);
    localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

    logic running;
    logic wrap;

    // an idle counter only stops once it is back at zero
    assign running = cnt_en || (count != '0);
    assign wrap    = running && (count == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            flag  <= 1'b0;
            tally <= '0;
        end else begin
            if (running) begin
                count <= wrap ? '0 : count + 1'b1;
            end
            if (wrap) begin
                flag <= 1'b1;
            end else if (ack) begin
                flag <= 1'b0;
            end
            if (wrap) begin
                if (ack) begin
                    tally <= TALLY_W'(1);
                end else if (tally != TALLY_MAX) begin
                    tally <= tally + 1'b1;
                end
            end else if (ack) begin
                tally <= '0;
            end
        end
    end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int EN_BIT  = 24,
    parameter int IEN_BIT = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wen,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               ren,
    input  logic [CNT_W-1:0]   count,
    input  logic               flag,
    input  logic [TALLY_W-1:0] tally,
    output logic [CNT_W-1:0]   limit,
    output logic               cnt_en,
    output logic               irq_en,
    output logic               ack_rd,
    output logic               peek_rd,
    output logic [DATA_W-1:0]  rdata
);
    localparam int VIEW_W = TALLY_W + CNT_W;

    pit_sel_e sel;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] view_word;

    assign sel     = pit_decode(PIT_ADDR_W'(addr));
    assign ack_rd  = ren && (sel == SEL_ACK);
    assign peek_rd = ren && (sel == SEL_PEEK);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit  <= {CNT_W{1'b1}};
            cnt_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (wen && sel == SEL_CONFIG) begin
            limit  <= wdata[CNT_W-1:0];
            cnt_en <= wdata[EN_BIT];
            irq_en <= wdata[IEN_BIT];
        end
    end

    always_comb begin
        cfg_word = '0;
        cfg_word[CNT_W-1:0] = limit;
        cfg_word[EN_BIT]    = cnt_en;
        cfg_word[IEN_BIT]   = irq_en;
    end

    generate
        if (VIEW_W >= DATA_W) begin : g_view_full
            assign view_word = DATA_W'({tally, count});
        end else begin : g_view_pad
            assign view_word = {{(DATA_W-VIEW_W){1'b0}}, tally, count};
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_CONFIG: rdata = cfg_word;
            SEL_STATUS: rdata = {{(DATA_W-1){1'b0}}, flag};
            SEL_ACK:    rdata = view_word;
            SEL_PEEK:   rdata = view_word;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
    import pit_pkg::*;
#(
    parameter int CNT_W   = PIT_CNT_W,
    parameter int TALLY_W = PIT_TALLY_W,
    parameter int DATA_W  = PIT_DATA_W,
    parameter int ADDR_W  = PIT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ren,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]   limit;
    logic               cnt_en;
    logic               irq_en;
    logic               ack_rd;
    logic               peek_rd;
    logic [CNT_W-1:0]   count;
    logic               flag;
    logic [TALLY_W-1:0] tally;

    pit_regs #(
        .CNT_W(CNT_W), .TALLY_W(TALLY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .EN_BIT(PIT_EN_BIT), .IEN_BIT(PIT_IEN_BIT)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wen(bus_wen), .wdata(bus_wdata),
        .ren(bus_ren), .count(count), .flag(flag), .tally(tally),
        .limit(limit), .cnt_en(cnt_en), .irq_en(irq_en),
        .ack_rd(ack_rd), .peek_rd(peek_rd), .rdata(bus_rdata)
    );

    pit_core #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_core (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .limit(limit), .ack(ack_rd),
        .count(count), .flag(flag), .tally(tally)
    );

    assign irq = flag && irq_en;
endmodule

// File: rtl/pit_chk.sv
module pit_chk #(
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               cnt_en,
    input logic [CNT_W-1:0]   limit,
    input logic [CNT_W-1:0]   count,
    input logic               flag,
    input logic [TALLY_W-1:0] tally,
    input logic               ack_rd,
    input logic               peek_rd
);
    localparam logic [TALLY_W-1:0] TMAX = {TALLY_W{1'b1}};

    logic act;
    logic at_end;
    assign act    = cnt_en || (count != '0);
    assign at_end = act && (count == limit);

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (act && !at_end) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        at_end |=> (count == '0 && flag));

    // R5
    tally_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (tally == TMAX && !ack_rd) |=> (tally == TMAX));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !at_end) |=> (!flag && tally == '0));

    // R7
    peek_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (peek_rd && !at_end) |=> ($stable(flag) && $stable(tally)));

    // R8
    ack_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && at_end) |=> (flag && tally == TALLY_W'(1)));

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && count == '0) |=> (count == '0));
endmodule

bind periodic_tick_timer pit_chk #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_pit_chk (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .limit(limit), .count(count),
    .flag(flag), .tally(tally), .ack_rd(ack_rd), .peek_rd(peek_rd)
);

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    periodic_tick_timer i_periodic_tick_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    // bench reference state, built from the requirements
    logic [19:0] m_lim = 20'hFFFFF;
    logic        m_en  = 0;
    logic        m_ien = 0;
    logic [19:0] m_cnt = 0;
    logic        m_flag = 0;
    logic [11:0] m_tal = 0;

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return {6'd0, m_ien, m_en, 4'd0, m_lim};
            2'd1:    return {31'd0, m_flag};
            default: return {m_tal, m_cnt};
        endcase
    endfunction

    task automatic model_step(input bit wr, input bit rd, input logic [3:0] a,
                              input logic [31:0] d);
        bit run, wrp, ack;
        run = m_en || (m_cnt != 0);
        wrp = run && (m_cnt == m_lim);
        ack = rd && (a[3:2] == 2'd2);
        if (run) m_cnt = wrp ? 20'd0 : m_cnt + 20'd1;
        if (wrp) m_flag = 1;
        else if (ack) m_flag = 0;
        if (wrp) m_tal = ack ? 12'd1 : ((m_tal == 12'hFFF) ? m_tal : m_tal + 12'd1);
        else if (ack) m_tal = 0;
        if (wr && a[3:2] == 2'd0) begin
            m_lim = d[19:0];
            m_en  = d[24];
            m_ien = d[25];
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // kind: 0 idle, 1 write, 2 read
    task automatic op(input int kind, input logic [3:0] a, input logic [31:0] d,
                      input string tag);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = (kind == 1);
        bus_ren   = (kind == 2);
        #1;
        if (kind == 2) chk(tag, bus_rdata, exp_read(a));
        chk("R10", {31'd0, irq}, {31'd0, m_flag & m_ien});
        @(posedge clk);
        model_step(kind == 1, kind == 2, a, d);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        op(2, 4'h0, 0, "R1");
        op(2, 4'h4, 0, "R1");
        op(2, 4'h8, 0, "R1");
        op(2, 4'hC, 0, "R1");

        // R2 field placement, enable left off
        op(1, 4'h0, 32'hFEFF_FFFF, "R2");
        op(2, 4'h0, 0, "R2");

        // R12 writes to read-only offsets
        op(1, 4'h4, 32'hFFFF_FFFF, "R12");
        op(1, 4'h8, 32'hFFFF_FFFF, "R12");
        op(1, 4'hC, 32'hFFFF_FFFF, "R12");
        op(2, 4'h0, 0, "R12");
        op(2, 4'h4, 0, "R12");
        op(2, 4'hC, 0, "R12");

        // R3 / R4 limit 5 with counting on
        op(1, 4'h0, 32'h0100_0005, "R3");
        for (int i = 0; i < 5; i++) op(2, 4'hC, 0, "R3");
        for (int i = 0; i < 8; i++) op(2, 4'hC, 0, "R4");
        op(2, 4'h4, 0, "R4");

        // R6 acknowledge, then look again
        op(2, 4'h8, 0, "R6");
        op(2, 4'hC, 0, "R6");
        op(2, 4'h4, 0, "R6");

        // R8 acknowledge exactly on the wrap cycle
        while (m_cnt != 20'd5) op(0, 0, 0, "");
        op(2, 4'h8, 0, "R8");
        op(2, 4'h4, 0, "R8");
        op(2, 4'hC, 0, "R8");

        // R9 stop request mid-period with a longer limit
        op(1, 4'h0, 32'h0000_0009, "R9");
        for (int i = 0; i < 16; i++) op(2, 4'hC, 0, "R9");

        // R5 saturation: wrap every cycle
        op(1, 4'h0, 32'h0300_0000, "R5");
        for (int i = 0; i < 4200; i++) op(0, 0, 0, "");
        op(2, 4'hC, 0, "R5");
        op(2, 4'h8, 0, "R5");
        op(2, 4'hC, 0, "R5");

        // random mix with small limits
        for (int i = 0; i < 2500; i++) begin
            int r;
            r = $urandom % 8;
            case (r)
                3: op(2, 4'h8, 0, "R6");
                4: op(2, 4'hC, 0, "R7");
                5: op(2, 4'h4, 0, "R11");
                6: op(1, 4'h0, {6'd0, 2'($urandom), 4'd0, 20'($urandom % 12)}, "R2");
                7: op(2, 4'h0, 0, "R2");
                default: op(0, 0, 0, "");
            endcase
        end

        finish_run();
    end
endmodule